// File: doc/BRIEF.md
# Tagged Multichannel Conversion Scan Sequencer

This block steps an analog input multiplexer through a window of channels, one channel per conversion trigger. Software programs the window with a single scan-window write that holds the lowest and highest channel, and programs a small per-channel setting table. Each entry is a 6-bit range code carrying a differential flag, a unipolar flag and a gain index. When a trigger arrives and no conversion is pending, the block presents the current channel and that channel's stored code to the converter. It holds the request until the converter acknowledges and advances its scan pointer.

Each returned 12-bit value is packed with the channel it came from into one result word, so downstream logic can spot a lost or duplicated sample. The scan wraps from the last channel back to the first, channel arithmetic wraps modulo the channel count, and a differential entry on an even channel uses that channel and its odd partner, so the pointer steps over the partner.

Top module: `adc_scan_seq`

## Requirements
- R1: After reset, conv_req, res_valid and overrun are low, the scan window is channel 0 to channel 0, and every range-table entry reads back as code 0 (single-ended, bipolar, gain index 0).
- R2: A configuration write with cfg_sel = 0 loads the scan window: cfg_wdata[7:0] is the first channel and cfg_wdata[15:8] the last channel (low 4 bits used for 16 channels). The scan pointer moves to the first channel on that clock edge. If a trigger is accepted on the same edge, that conversion uses the old pointer and the next one starts at the new first channel.
- R3: A configuration write with cfg_sel = 1 stores cfg_wdata[5:0] into the range-table entry of the window's first channel, so setting first = last selects one entry. Code layout: bit 5 differential, bit 4 unipolar, bits 2:0 gain index.
- R4: A trigger with no conversion pending raises conv_req on the next cycle, with conv_chan equal to the scan pointer and conv_code equal to that channel's range-table entry. conv_req, conv_chan and conv_code stay unchanged until conv_ack is sampled high.
- R5: After a single-ended channel the pointer moves to the next channel. After the last channel it returns to the first, and channel 15 is followed by channel 0.
- R6: After a differential channel the pointer moves up by two (modulo 16). If that channel or its odd partner is the last channel, it returns to the first.
- R7: On the cycle after conv_ack is sampled with conv_req high, conv_req is low and res_valid is high for exactly one cycle, with res_word[15:12] = the converted channel and res_word[11:0] = conv_data.
- R8: A trigger while conv_req is high, including the acknowledge cycle, starts nothing and does not move the pointer. It sets overrun, which stays high until reset.
- R9: A scan-window write during a pending conversion leaves that conversion and its result tag unchanged, and the next conversion uses the new first channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = scan window, 1 = range-table entry |
| cfg_wdata | input | 16 | Configuration write data |
| trig | input | 1 | Conversion trigger |
| conv_req | output | 1 | Conversion request to the converter |
| conv_chan | output | 4 | Multiplexer channel for the pending conversion |
| conv_code | output | 6 | Range code for the pending conversion |
| conv_ack | input | 1 | Converter acknowledge, with conv_data valid |
| conv_data | input | 12 | Converted value |
| res_valid | output | 1 | One-cycle result strobe |
| res_word | output | 16 | Channel tag and converted value |
| overrun | output | 1 | Sticky flag for a rejected trigger |

## Verification
Scan-window reload and trigger acceptance can fall on the same clock edge. The pointer advance for an accepted trigger is also applied one edge later, so a window write can meet a pending advance. The bench raises trig and a window write in the same cycle, and also writes the window on the advance edge of a pending conversion. It then checks that the captured channel is the old pointer, that the result tag matches it, and that the next conversion starts exactly at the new first channel. A trigger raised in the same cycle as conv_ack is also checked: it must be rejected, flagged, and leave the pointer where the scan model predicts.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

  // 6-bit range code: [5] differential, [4] unipolar, [3] spare, [2:0] gain
  typedef struct packed {
    logic       diff;
    logic       uni;
    logic       spare;
    logic [2:0] gain;
  } range_code_t;

  localparam int CODE_W = $bits(range_code_t);

  // Configuration targets selected by cfg_sel
  localparam logic SEL_WINDOW = 1'b0;
  localparam logic SEL_RANGE  = 1'b1;

endpackage

// File: rtl/adc_range_mem.sv
module adc_range_mem
  import adc_scan_pkg::*;
#(
  parameter int N_CH = 16,
  parameter int AW   = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  range_code_t   wr_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output range_code_t   rd_data
);

  range_code_t mem [N_CH];

  // Table must come out of reset as all zero codes
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N_CH; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_addr] <= wr_data;
    end
  end

  // Registered read port, loaded only when a conversion is accepted
  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/adc_scan_ptr.sv
module adc_scan_ptr #(
  parameter int N_CH = 16,
  parameter int AW   = $clog2(N_CH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [AW-1:0] load_first,
  input  logic [AW-1:0] load_last,
  input  logic          step,
  input  logic [AW-1:0] cur_chan,
  input  logic          cur_diff,
  output logic [AW-1:0] ptr,
  output logic [AW-1:0] first,
  output logic [AW-1:0] last
);

  localparam logic [AW-1:0] TOP_CH = AW'(N_CH - 1);

  logic          load_q;
  logic [AW-1:0] inc1, inc2, nxt;
  logic          at_end;

  always_comb begin
    inc1   = (cur_chan == TOP_CH) ? '0 : cur_chan + 1'b1;
    inc2   = (inc1 == TOP_CH) ? '0 : inc1 + 1'b1;
    at_end = (cur_chan == last) || (cur_diff && (inc1 == last));
    nxt    = at_end ? first : (cur_diff ? inc2 : inc1);
  end

  // A window load wins over a pending step, and also cancels a step
  // that belongs to a conversion accepted on the loading edge.
  always_ff @(posedge clk) begin
    if (rst) begin
      ptr    <= '0;
      first  <= '0;
      last   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= load;
      if (load) begin
        first <= load_first;
        last  <= load_last;
        ptr   <= load_first;
      end else if (step && !load_q) begin
        ptr <= nxt;
      end
    end
  end

endmodule

// File: rtl/adc_conv_ctl.sv
module adc_conv_ctl #(
  parameter int AW    = 4,
  parameter int RES_W = 12,
  parameter int WORD_W = AW + RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig,
  input  logic [AW-1:0]     ptr,
  input  logic              conv_ack,
  input  logic [RES_W-1:0]  conv_data,
  output logic              accept,
  output logic              adv,
  output logic              conv_req,
  output logic [AW-1:0]     conv_chan,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              overrun
);

  assign accept = trig && !conv_req;

  always_ff @(posedge clk) begin
    if (rst) begin
      adv       <= 1'b0;
      conv_req  <= 1'b0;
      conv_chan <= '0;
      res_valid <= 1'b0;
      res_word  <= '0;
      overrun   <= 1'b0;
    end else begin
      adv       <= accept;
      res_valid <= 1'b0;
      if (accept) begin
        conv_req  <= 1'b1;
        conv_chan <= ptr;
      end else if (conv_req && conv_ack) begin
        conv_req  <= 1'b0;
        res_valid <= 1'b1;
        res_word  <= {conv_chan, conv_data};
      end
      if (trig && conv_req) overrun <= 1'b1;
    end
  end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int N_CH   = 16,
  parameter int RES_W  = 12,
  parameter int CFG_W  = 16,
  parameter int HI_LSB = 8,
  localparam int AW     = $clog2(N_CH),
  localparam int WORD_W = AW + RES_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_sel,
  input  logic [CFG_W-1:0]  cfg_wdata,
  input  logic              trig,
  output logic              conv_req,
  output logic [AW-1:0]     conv_chan,
  output logic [CODE_W-1:0] conv_code,
  input  logic              conv_ack,
  input  logic [RES_W-1:0]  conv_data,
  output logic              res_valid,
  output logic [WORD_W-1:0] res_word,
  output logic              overrun
);

  logic          win_wr, rng_wr, accept, adv;
  logic [AW-1:0] ptr, first, last;
  range_code_t   cur_code;

  assign win_wr = cfg_wr && (cfg_sel == SEL_WINDOW);
  assign rng_wr = cfg_wr && (cfg_sel == SEL_RANGE);

  adc_range_mem #(.N_CH(N_CH), .AW(AW)) u_mem (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rng_wr),
    .wr_addr (first),
    .wr_data (range_code_t'(cfg_wdata[CODE_W-1:0])),
    .rd_en   (accept),
    .rd_addr (ptr),
    .rd_data (cur_code)
  );

  adc_scan_ptr #(.N_CH(N_CH), .AW(AW)) u_ptr (
    .clk        (clk),
    .rst        (rst),
    .load       (win_wr),
    .load_first (cfg_wdata[AW-1:0]),
    .load_last  (cfg_wdata[HI_LSB +: AW]),
    .step       (adv),
    .cur_chan   (conv_chan),
    .cur_diff   (cur_code.diff),
    .ptr        (ptr),
    .first      (first),
    .last       (last)
  );

  adc_conv_ctl #(.AW(AW), .RES_W(RES_W), .WORD_W(WORD_W)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .trig      (trig),
    .ptr       (ptr),
    .conv_ack  (conv_ack),
    .conv_data (conv_data),
    .accept    (accept),
    .adv       (adv),
    .conv_req  (conv_req),
    .conv_chan (conv_chan),
    .res_valid (res_valid),
    .res_word  (res_word),
    .overrun   (overrun)
  );

  assign conv_code = cur_code;

endmodule

// File: rtl/adc_scan_seq_chk.sv
module adc_scan_seq_chk #(
  parameter int AW     = 4,
  parameter int RES_W  = 12,
  parameter int CODE_W = 6
) (
  input logic              clk,
  input logic              rst,
  input logic              trig,
  input logic              conv_req,
  input logic [AW-1:0]     conv_chan,
  input logic [CODE_W-1:0] conv_code,
  input logic              conv_ack,
  input logic [RES_W-1:0]  conv_data,
  input logic              res_valid,
  input logic [AW+RES_W-1:0] res_word,
  input logic              overrun
);

  // R4: request held with stable channel and code until acknowledged
  p_req_hold_r4: assert property (@(posedge clk) disable iff (rst)
    conv_req && !conv_ack |=> conv_req && $stable(conv_chan) && $stable(conv_code));

  // R7: acknowledge ends the request and strobes a result
  p_ack_result_r7: assert property (@(posedge clk) disable iff (rst)
    conv_req && conv_ack |=> res_valid && !conv_req);

  // R7: result tag and value come from the acknowledged conversion
  p_tag_r7: assert property (@(posedge clk) disable iff (rst)
    conv_req && conv_ack |=> (res_word[AW+RES_W-1 -: AW] == $past(conv_chan))
                             && (res_word[RES_W-1:0] == $past(conv_data)));

  // R7: strobe lasts one cycle
  p_valid_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R8: busy trigger sets the flag
  p_overrun_set_r8: assert property (@(posedge clk) disable iff (rst)
    trig && conv_req |=> overrun);

  // R8: flag is sticky
  p_overrun_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    overrun |=> overrun);

endmodule

bind adc_scan_seq adc_scan_seq_chk #(.AW(AW), .RES_W(RES_W), .CODE_W(adc_scan_pkg::CODE_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .trig      (trig),
  .conv_req  (conv_req),
  .conv_chan (conv_chan),
  .conv_code (conv_code),
  .conv_ack  (conv_ack),
  .conv_data (conv_data),
  .res_valid (res_valid),
  .res_word  (res_word),
  .overrun   (overrun)
);

// File: tb/adc_scan_seq_bench.sv
module adc_scan_seq_bench;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic        cfg_sel = 1'b0;
  logic [15:0] cfg_wdata = '0;
  logic        trig = 1'b0;
  logic        conv_req;
  logic [3:0]  conv_chan;
  logic [5:0]  conv_code;
  logic        conv_ack = 1'b0;
  logic [11:0] conv_data = '0;
  logic        res_valid;
  logic [15:0] res_word;
  logic        overrun;

  int checks = 0;
  int errors = 0;
  int nres = 0;

  // Bench scan model
  logic [5:0] code_m [16];
  int first_m = 0, last_m = 0, ptr_m = 0;

  always #(CLK_P/2) clk = ~clk;

  adc_scan_seq u_adc_scan_seq (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .trig(trig), .conv_req(conv_req), .conv_chan(conv_chan), .conv_code(conv_code),
    .conv_ack(conv_ack), .conv_data(conv_data), .res_valid(res_valid),
    .res_word(res_word), .overrun(overrun)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [5:0] code_of(int ch);
    logic d;
    d = (ch == 4) || (ch == 8) || (ch == 14);
    return {d, ch[0], 1'b0, ch[2:0]};
  endfunction

  function automatic int next_of(int cur);
    bit d;
    int p1;
    d  = code_m[cur][5];
    p1 = (cur + 1) % 16;
    if (cur == last_m || (d && p1 == last_m)) return first_m;
    return d ? (cur + 2) % 16 : p1;
  endfunction

  task automatic cfg_write(logic sel, logic [15:0] data);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = data;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic set_window(int f, int l);
    cfg_write(1'b0, {8'(l), 8'(f)});
    first_m = f; last_m = l; ptr_m = f;
  endtask

  task automatic start_conv(int ch);
    @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk("R4 req", 32'(conv_req), 32'd1);
    chk("R4 chan", 32'(conv_chan), 32'(ch));
    chk("R4 code", 32'(conv_code), 32'(code_m[ch]));
  endtask

  task automatic finish_conv(int ch);
    logic [11:0] d;
    d = 12'(ch * 173 + nres * 29);
    nres++;
    conv_ack = 1'b1; conv_data = d;
    @(negedge clk);
    conv_ack = 1'b0;
    chk("R7 valid", 32'(res_valid), 32'd1);
    chk("R7 req low", 32'(conv_req), 32'd0);
    chk("R7 word", 32'(res_word), {16'd0, 4'(ch), d});
    @(negedge clk);
    chk("R7 pulse", 32'(res_valid), 32'd0);
  endtask

  task automatic scan(int n, string tag);
    for (int k = 0; k < n; k++) begin
      start_conv(ptr_m);
      finish_conv(ptr_m);
      ptr_m = next_of(ptr_m);
    end
    $display("scan %s done", tag);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int old;
    for (int i = 0; i < 16; i++) code_m[i] = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk("R1 req", 32'(conv_req), 32'd0);
    chk("R1 valid", 32'(res_valid), 32'd0);
    chk("R1 overrun", 32'(overrun), 32'd0);
    scan(2, "R1 default window");

    // R1 zero table, R3 entry write, swept over every channel
    for (int ch = 0; ch < 16; ch++) begin
      set_window(ch, ch);
      scan(1, "R1 zero entry");
      cfg_write(1'b1, 16'(code_of(ch)));
      code_m[ch] = code_of(ch);
      scan(1, "R3 entry");
    end

    // R5 / R6 window sweeps, including modulo wrap and differential pairs
    set_window(0, 15);  scan(20, "R5 R6 full");
    set_window(5, 9);   scan(9, "R6 diff at end");
    set_window(14, 1);  scan(8, "R5 R6 modulo wrap");
    set_window(2, 9);   scan(10, "R6 skip odd partner");
    set_window(3, 3);   scan(3, "R5 single");
    set_window(12, 2);  scan(12, "R5 R6 wrap window");

    // R8: busy trigger and acknowledge-cycle trigger
    set_window(0, 15);
    chk("R8 clear before", 32'(overrun), 32'd0);
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    chk("R8 overrun", 32'(overrun), 32'd1);
    chk("R8 chan", 32'(conv_chan), 32'd0);
    conv_ack = 1'b1; conv_data = 12'h5a5; trig = 1'b1;
    @(negedge clk);
    conv_ack = 1'b0; trig = 1'b0;
    chk("R8 one result", 32'(res_word), 32'h05a5);
    chk("R8 ack-cycle trig ignored", 32'(conv_req), 32'd0);
    @(negedge clk);
    chk("R8 still idle", 32'(conv_req), 32'd0);
    ptr_m = next_of(0);
    scan(2, "R8 pointer unmoved");
    chk("R8 sticky", 32'(overrun), 32'd1);

    // R9: window write on the advance edge of a pending conversion
    old = ptr_m;
    start_conv(old);
    cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {8'd9, 8'd5};
    @(negedge clk);
    cfg_wr = 1'b0;
    chk("R9 still pending", 32'(conv_req), 32'd1);
    chk("R9 chan kept", 32'(conv_chan), 32'(old));
    first_m = 5; last_m = 9; ptr_m = 5;
    finish_conv(old);
    scan(3, "R9 restart");

    // R2: trigger and window write in the same cycle
    old = ptr_m;
    @(negedge clk);
    trig = 1'b1; cfg_wr = 1'b1; cfg_sel = 1'b0; cfg_wdata = {8'd2, 8'd12};
    @(negedge clk);
    trig = 1'b0; cfg_wr = 1'b0;
    chk("R2 old chan", 32'(conv_chan), 32'(old));
    chk("R2 old code", 32'(conv_code), 32'(code_m[old]));
    first_m = 12; last_m = 2; ptr_m = 12;
    finish_conv(old);
    scan(7, "R2 new window");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule